// File: doc/BRIEF.md
# Phase-Continuous Two-Tone FSK Synthesizer

This block is the digital front half of a frequency-shift-keyed line modulator. A serial bit stream arrives on a single data input. Each clock, a shared phase accumulator advances by one of two fixed tuning words. A logic 1 (mark) selects the 1200 Hz word and a logic 0 (space) selects the 2200 Hz word. The top bits of the accumulator address a quarter-wave sine table. The result is a signed sine sample that a downstream converter turns into a line signal.

The tuning words are computed at elaboration from the clock-rate parameter. The same code therefore serves a 3.6864 MHz crystal clock and a 1.2288 MHz on-chip oscillator clock. The data line is followed level for level, with no framing: at 1200 bit/s each bit simply holds one tone for 833.33 µs. The accumulator is never cleared on a tone change, so the waveform has no phase step at bit boundaries.

A low-active transmit request gates the synthesizer. A duplex input keeps it running regardless of that request, so that loopback self-test can run alongside reception. Whenever the synthesizer is gated off, the output is the zero code and the phase is parked at zero. Samples leave at a decimated rate, with a one-clock strobe.

Top module: `fsk_tone_synth`

## Requirements
- R1: With the synthesizer running and `tx_bit`=1, the output is a 1200 Hz sine. At the default 3.6864 MHz clock and decimation of 32, rising zero crossings are 96 to 97 samples apart. Each running clock advances the phase by round(1200·2^24/CLK_HZ).
- R2: With the synthesizer running and `tx_bit`=0, the output is a 2200 Hz sine, with rising zero crossings 52 to 53 samples apart at default parameters. Each running clock advances the phase by round(2200·2^24/CLK_HZ).
- R3: A change of `tx_bit` never clears or jumps the phase. No two consecutive samples differ by more than 255·2π·TW_space·32/2^24 + 2 codes (33 at defaults), including across tone switches.
- R4: When `rts_n`=1 and `duplex`=0, every strobed sample is 0 and the phase is held at zero. The first strobed sample after running starts is therefore positive and no larger than the R3 bound.
- R5: With `duplex`=1, the synthesizer runs and follows `tx_bit` whatever the level of `rts_n`.
- R6: `sample_valid` is a single-cycle pulse that repeats every DECIM clocks (32 by default), running or not.
- R7: The tuning words follow CLK_HZ. With CLK_HZ=1228800, mark crossings are 32 to 33 samples apart and space crossings are 17 to 18 samples apart.
- R8: While `rst_n` is low, `sample` is 0 and `sample_valid` is 0.
- R9: Sample magnitude never exceeds 2^MAG_W−1 (255). The sign is negative exactly in the second half of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit | input | 1 | Data level: 1 selects mark tone, 0 selects space tone |
| rts_n | input | 1 | Low-active transmit request; low lets the synthesizer run |
| duplex | input | 1 | High keeps the synthesizer running independent of `rts_n` |
| sample | output | MAG_W+1 (9) | Two's-complement sine sample, 0 when idle |
| sample_valid | output | 1 | One-clock strobe marking a new `sample` |

## Verification
A tone switch and a decimation tick can land in the same clock. In that cycle the accumulator takes its first step with the new word while the output register captures the phase left by the old word. The bench provokes this by holding each bit for exactly 3072 clocks, a multiple of the decimation period, so that every switch lands at one fixed offset from the strobe. Over many switches, the step between the strobe before and the strobe after each switch is judged against the slope bound of R3. A second collision, between the gate opening and a tick, is swept by releasing `rts_n` at several offsets after a strobe. Each time, the first sample must be the small positive start-of-cycle value.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  // Phase increment per clock for a tone: round(f * 2^accw / clk).
  function automatic longint unsigned tuning_word(input longint unsigned tone_hz,
                                                  input longint unsigned clk_hz,
                                                  input int unsigned accw);
    longint unsigned num;
    num = tone_hz << accw;
    return (num + (clk_hz >> 1)) / clk_hz;
  endfunction

  // Quarter-wave table entry: sampled at mid-bin so the fold is symmetric.
  function automatic int unsigned qsine_mag(input int unsigned idx,
                                            input int unsigned entries,
                                            input int unsigned full_scale);
    real ang;
    ang = 3.14159265358979 * (real'(idx) + 0.5) / (2.0 * real'(entries));
    return $rtoi(real'(full_scale) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/fsk_decimator.sv
module fsk_decimator #(
  parameter int unsigned DECIM = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int unsigned ACC_W = 24,
  parameter logic [ACC_W-1:0] TW_MARK  = '0,
  parameter logic [ACC_W-1:0] TW_SPACE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             mark_sel,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] step;

  assign step = mark_sel ? TW_MARK : TW_SPACE;

  // Shared accumulator: tone changes only alter the step, never the phase.
  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (!run) acc <= '0;
    else           acc <= acc + step;
  end
endmodule

// File: rtl/fsk_quarter_rom.sv
module fsk_quarter_rom #(
  parameter int unsigned PH_W  = 10,
  parameter int unsigned MAG_W = 8
) (
  input  logic [PH_W-1:0]         phase,
  output logic signed [MAG_W:0]   wave
);
  localparam int unsigned AW      = PH_W - 2;
  localparam int unsigned ENTRIES = 1 << AW;
  localparam int unsigned FULL    = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_tbl
    assign tbl[i] = MAG_W'(fsk_pkg::qsine_mag(i, ENTRIES, FULL));
  end

  logic          mirror;
  logic          negate;
  logic [AW-1:0] addr;
  logic [MAG_W-1:0] mag;

  assign mirror = phase[PH_W-2];
  assign negate = phase[PH_W-1];
  assign addr   = mirror ? ~phase[AW-1:0] : phase[AW-1:0];
  assign mag    = tbl[addr];
  assign wave   = negate ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth #(
  parameter int unsigned CLK_HZ   = 3686400,
  parameter int unsigned MARK_HZ  = 1200,
  parameter int unsigned SPACE_HZ = 2200,
  parameter int unsigned ACC_W    = 24,
  parameter int unsigned PH_W     = 10,
  parameter int unsigned MAG_W    = 8,
  parameter int unsigned DECIM    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_bit,
  input  logic                  rts_n,
  input  logic                  duplex,
  output logic signed [MAG_W:0] sample,
  output logic                  sample_valid
);
  localparam logic [ACC_W-1:0] TW_MARK  =
    ACC_W'(fsk_pkg::tuning_word(MARK_HZ, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] TW_SPACE =
    ACC_W'(fsk_pkg::tuning_word(SPACE_HZ, CLK_HZ, ACC_W));

  logic                  mod_run;
  logic [ACC_W-1:0]      acc_q;
  logic [PH_W-1:0]       phase;
  logic signed [MAG_W:0] wave;
  logic                  tick;

  assign mod_run = !rts_n || duplex;

  fsk_phase_acc #(
    .ACC_W(ACC_W), .TW_MARK(TW_MARK), .TW_SPACE(TW_SPACE)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .run(mod_run), .mark_sel(tx_bit), .acc(acc_q)
  );

  assign phase = acc_q[ACC_W-1 -: PH_W];

  fsk_quarter_rom #(.PH_W(PH_W), .MAG_W(MAG_W)) u_rom (
    .phase(phase), .wave(wave)
  );

  fsk_decimator #(.DECIM(DECIM)) u_dec (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= tick;
      if (tick) sample <= mod_run ? wave : '0;
    end
  end
endmodule

// File: rtl/fsk_tone_synth_chk.sv
module fsk_tone_synth_chk #(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned MAG_W = 8,
  parameter int unsigned DECIM = 32,
  parameter logic [ACC_W-1:0] TW_MARK  = '0,
  parameter logic [ACC_W-1:0] TW_SPACE = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tx_bit,
  input logic                  mod_run,
  input logic [ACC_W-1:0]      acc_q,
  input logic signed [MAG_W:0] sample,
  input logic                  sample_valid
);
  localparam int FULL = (1 << MAG_W) - 1;

  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (sample_valid) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  // R1
  mark_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mod_run) && $past(tx_bit) |-> (acc_q - $past(acc_q)) == TW_MARK);

  // R2
  space_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mod_run) && !$past(tx_bit) |-> (acc_q - $past(acc_q)) == TW_SPACE);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_run |=> acc_q == '0);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !$past(mod_run) |-> sample == '0);

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && seen_q |-> gap_q == DECIM - 1);

  // R9
  magnitude_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample <= FULL) && (sample >= -FULL));
endmodule

bind fsk_tone_synth fsk_tone_synth_chk #(
  .ACC_W(ACC_W), .MAG_W(MAG_W), .DECIM(DECIM),
  .TW_MARK(TW_MARK), .TW_SPACE(TW_SPACE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .mod_run(mod_run),
  .acc_q(acc_q), .sample(sample), .sample_valid(sample_valid)
);

// File: tb/tb_fsk_tone_synth.sv
`timescale 1ns/1ps
module tb_fsk_tone_synth;
  localparam real CLK_A = 3686400.0;
  localparam real CLK_B = 1228800.0;
  localparam real DEC   = 32.0;
  localparam real PI    = 3.14159265358979;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tx_bit = 1'b1, rts_n = 1'b1, duplex = 1'b0;
  logic signed [8:0] s_a, s_b;
  logic v_a, v_b;

  fsk_tone_synth dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .rts_n(rts_n), .duplex(duplex),
    .sample(s_a), .sample_valid(v_a));

  fsk_tone_synth #(.CLK_HZ(1228800)) dut_rc (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .rts_n(rts_n), .duplex(duplex),
    .sample(s_b), .sample_valid(v_b));

  int total = 0, bad = 0;
  bit done = 1'b0;
  real bound;

  // {rts_n, duplex, tx_bit, kind[1:0]}; kind 0 idle, 1 mark, 2 space
  localparam logic [4:0] VEC [7] = '{
    5'b0_0_1_01, 5'b0_0_0_10, 5'b1_0_1_00, 5'b1_1_1_01,
    5'b1_1_0_10, 5'b0_1_0_10, 5'b1_0_0_00 };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_valid();
    do @(negedge clk); while (!v_a);
  endtask

  function automatic int per_lo(input real clk_hz, input real f);
    return $rtoi($floor(clk_hz / (f * DEC)));
  endfunction

  task automatic check_period(input string req, input int per, input real clk_hz, input real f);
    int lo;
    lo = per_lo(clk_hz, f);
    check(per >= lo && per <= lo + 1, req, per, lo);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    bound = 255.0 * 2.0 * PI * $floor(2200.0 * 16777216.0 / CLK_A + 0.5) * DEC / 16777216.0 + 2.0;

    // R8: reset state
    repeat (5) @(negedge clk);
    check(s_a == 0, "R8 sample in reset", s_a, 0);
    check(v_a == 0, "R8 valid in reset", v_a, 0);
    rst_n = 1'b1;

    // Vector table: tone and gating per vector, both clock rates
    for (int k = 0; k < 7; k++) begin
      int prev_a, prev_b, last_a, last_b, per_a, per_b, nz;
      {rts_n, duplex, tx_bit} = VEC[k][4:2];
      repeat (3) next_valid();
      prev_a = 0; prev_b = 0; last_a = -1; last_b = -1; per_a = 0; per_b = 0; nz = 0;
      for (int n = 0; n < 250; n++) begin
        next_valid();
        if (s_a != 0 || s_b != 0) nz++;
        if (prev_a < 0 && s_a > 0) begin
          if (last_a >= 0) per_a = n - last_a;
          last_a = n;
        end
        if (prev_b < 0 && s_b > 0) begin
          if (last_b >= 0) per_b = n - last_b;
          last_b = n;
        end
        prev_a = s_a; prev_b = s_b;
      end
      case (VEC[k][1:0])
        2'd0: begin
          check(nz == 0, "R4 idle samples nonzero count", nz, 0);
          check(nz == 0, "R4 idle samples (slow clock)", nz, 0);
        end
        2'd1: begin
          check_period(duplex ? "R5 R1 mark period in duplex" : "R1 mark period", per_a, CLK_A, 1200.0);
          check_period("R7 mark period at slow clock", per_b, CLK_B, 1200.0);
        end
        default: begin
          check_period(duplex ? "R5 R2 space period in duplex" : "R2 space period", per_a, CLK_A, 2200.0);
          check_period("R7 space period at slow clock", per_b, CLK_B, 2200.0);
        end
      endcase
    end

    // R3: bit stream with switches every bit time, max sample-to-sample step
    begin
      logic [15:0] pattern = 16'hA5C3;
      int prev, maxd, d;
      bit have;
      rts_n = 1'b0; duplex = 1'b0; have = 1'b0; maxd = 0; prev = 0;
      for (int b = 0; b < 16; b++) begin
        tx_bit = pattern[b];
        for (int c = 0; c < 3072; c++) begin
          @(negedge clk);
          if (v_a) begin
            d = (s_a > prev) ? s_a - prev : prev - s_a;
            if (have && d > maxd) maxd = d;
            prev = s_a; have = 1'b1;
          end
        end
      end
      check(maxd <= $rtoi(bound), "R3 largest step across tone switches", maxd, $rtoi(bound));
    end

    // R4: first sample after gate opens starts at phase zero
    for (int off = 0; off < 4; off++) begin
      rts_n = 1'b1; duplex = 1'b0; tx_bit = off[0];
      repeat (3) next_valid();
      repeat (off * 7) @(negedge clk);
      rts_n = 1'b0;
      next_valid();
      check(s_a > 0 && s_a <= $rtoi(bound), "R4 first sample after enable", s_a, 1);
    end

    // R6: strobe cadence
    begin
      int cnt, pairs;
      logic last;
      next_valid();
      cnt = 0; pairs = 0; last = 1'b1;
      for (int c = 0; c < 320; c++) begin
        @(negedge clk);
        if (v_a) cnt++;
        if (v_a && last) pairs++;
        last = v_a;
      end
      check(cnt == 10, "R6 strobes per 320 clocks", cnt, 10);
      check(pairs == 0, "R6 back-to-back strobes", pairs, 0);
    end

    // R8: reset in the middle of transmission
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(s_a == 0, "R8 sample after mid-run reset", s_a, 0);
    check(v_a == 0, "R8 valid after mid-run reset", v_a, 0);
    rst_n = 1'b1;

    summary();
  end
endmodule